// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and drives two processor request outputs: a fast output and a normal output. A per-source classification mask decides which output a source feeds. A separate per-source enable mask gates every source. The enable mask is changed through two write-only views. One view sets bits and the other clears them, so software never has to read the mask before it changes it.

Sixteen vector slots translate normal-class sources into handler addresses. Each slot holds a source channel number, a slot enable and a 32-bit handler address. Slots have a fixed priority: the lowest-numbered slot wins. The processor reads the vector register to fetch the address of the winning slot. That read freezes the vector for the whole service routine. Any write to the same register ends the service and lets the arbitration run again. If a normal-class source is pending and no enabled slot claims it, the vector register returns a programmable default address.

Registers sit behind a simple word-aligned port with one write strobe and one read strobe. Writes take effect on the next clock edge. Read data is combinational from the current state. Bit positions are fixed, and the number of slots may be at most 16.

Top module: `vic_top`

## Requirements
- R1: `fiq_o` is high in the same cycle exactly when some source has its request high, its enable bit 1 and its class bit 1. `irq_o` is high exactly when some such source has class bit 0.
- R2: A write to byte address 0x04 sets every enable bit whose data bit is 1 and leaves bits written 0 unchanged. A read of 0x04 returns the enable mask, which is 0 after reset.
- R3: A write to byte address 0x08 clears every enable bit whose data bit is 1 and leaves the other bits unchanged. A disabled source reaches neither output nor any slot.
- R4: The class mask at byte address 0x00 is read/write, one bit per source (bit n = source n). Class 1 means the fast class and 0 the normal class. The mask is 0 after reset.
- R5: Slot n control sits at byte address 0x40+4n, with the source channel in bits [4:0] and the slot enable in bit 5. Slot n handler address sits at 0x80+4n. Both read back as written.
- R6: A read of 0x10 returns the handler address of the lowest-numbered enabled slot whose channel is a pending normal-class source (request high, enable 1, class 0).
- R7: When no enabled slot matches a pending normal-class source, including when nothing is pending, a read of 0x10 returns the default address held at byte address 0x14. The default address is 0 after reset.
- R8: A read of 0x10 freezes the returned value. Later reads return the same value until a write of any data to 0x10, after which reads follow the live arbitration again.
- R9: A pending fast-class source never selects a slot and never changes the vector value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_SRC | Interrupt request lines, bit n = source n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a read of 0x10 freezes the vector) |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
Both request outputs and the read data are combinational, so each is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples two nanoseconds later, before the next rising edge. A register write counts from the rising edge that follows its falling-edge drive, so every read that must see the write is issued at a later falling edge. The freeze of the vector and its release take one edge each. The bench checks them by comparing reads issued on separate cycles around a change of requests and an end-of-service write.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CLASS  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_ENSET  = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_ENCLR  = 8'h08;
    localparam logic [ADDR_W-1:0] ADR_VECTOR = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_DFLT   = 8'h14;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_CLASS,
        REG_ENSET,
        REG_ENCLR,
        REG_VECTOR,
        REG_DFLT,
        REG_SCTL,
        REG_SADR
    } reg_e;

    // Slot control occupies 0x40..0x7C, slot address 0x80..0xBC; slot index in addr[5:2]
    function automatic reg_e reg_decode(input logic [ADDR_W-1:0] a);
        reg_e r;
        r = REG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[7:6])
                2'b01: r = REG_SCTL;
                2'b10: r = REG_SADR;
                2'b00: begin
                    case (a[5:2])
                        4'd0:    r = REG_CLASS;
                        4'd1:    r = REG_ENSET;
                        4'd2:    r = REG_ENCLR;
                        4'd4:    r = REG_VECTOR;
                        4'd5:    r = REG_DFLT;
                        default: r = REG_NONE;
                    endcase
                end
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int CH_W     = 5
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_en_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_SRC-1:0]               class_o,
    output logic [NUM_SRC-1:0]               enable_o,
    output logic [DATA_W-1:0]                dflt_o,
    output logic [NUM_SLOT-1:0]              slot_en_o,
    output logic [NUM_SLOT-1:0][CH_W-1:0]    slot_ch_o,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_adr_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]              cls;
        logic [NUM_SRC-1:0]              en;
        logic [DATA_W-1:0]               dflt;
        logic [NUM_SLOT-1:0]             s_en;
        logic [NUM_SLOT-1:0][CH_W-1:0]   s_ch;
        logic [NUM_SLOT-1:0][DATA_W-1:0] s_adr;
    } regs_t;

    regs_t st_d, st_q;
    reg_e  kind;
    logic [3:0] slot_idx;

    assign kind     = reg_decode(addr_i);
    assign slot_idx = addr_i[5:2];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (kind)
                REG_CLASS: st_d.cls  = wdata_i[NUM_SRC-1:0];
                REG_ENSET: st_d.en   = st_q.en | wdata_i[NUM_SRC-1:0];
                REG_ENCLR: st_d.en   = st_q.en & ~wdata_i[NUM_SRC-1:0];
                REG_DFLT:  st_d.dflt = wdata_i;
                REG_SCTL: begin
                    for (int n = 0; n < NUM_SLOT; n++) begin
                        if (32'(slot_idx) == n) begin
                            st_d.s_ch[n] = wdata_i[CH_W-1:0];
                            st_d.s_en[n] = wdata_i[CH_W];
                        end
                    end
                end
                REG_SADR: begin
                    for (int n = 0; n < NUM_SLOT; n++) begin
                        if (32'(slot_idx) == n) begin
                            st_d.s_adr[n] = wdata_i;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign class_o    = st_q.cls;
    assign enable_o   = st_q.en;
    assign dflt_o     = st_q.dflt;
    assign slot_en_o  = st_q.s_en;
    assign slot_ch_o  = st_q.s_ch;
    assign slot_adr_o = st_q.s_adr;

endmodule

// File: rtl/vic_slot_arb.sv
module vic_slot_arb #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int CH_W     = 5
) (
    input  logic [NUM_SRC-1:0]               pend_i,
    input  logic [NUM_SLOT-1:0]              slot_en_i,
    input  logic [NUM_SLOT-1:0][CH_W-1:0]    slot_ch_i,
    input  logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_adr_i,
    input  logic [DATA_W-1:0]                dflt_i,
    output logic [DATA_W-1:0]                vec_o
);

    logic [NUM_SLOT-1:0] hit;

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        assign hit[g] = slot_en_i[g] & pend_i[slot_ch_i[g]];
    end

    // Scan from the lowest priority upward so slot 0 overrides all others
    always_comb begin
        vec_o = dflt_i;
        for (int n = NUM_SLOT - 1; n >= 0; n--) begin
            if (hit[n]) begin
                vec_o = slot_adr_i[n];
            end
        end
    end

endmodule

// File: rtl/vic_vector.sv
module vic_vector #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fetch_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] live_i,
    output logic [DATA_W-1:0] vec_o,
    output logic              busy_o
);

    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] held;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i) begin
            st_d.busy = 1'b0;
        end else if (fetch_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.held = live_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o  = st_q.busy ? st_q.held : live_i;
    assign busy_o = st_q.busy;

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int CH_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]              class_q;
    logic [NUM_SRC-1:0]              en_q;
    logic [DATA_W-1:0]               dflt_q;
    logic [NUM_SLOT-1:0]             slot_en;
    logic [NUM_SLOT-1:0][CH_W-1:0]   slot_ch;
    logic [NUM_SLOT-1:0][DATA_W-1:0] slot_adr;
    logic [NUM_SRC-1:0]              irq_pend;
    logic [NUM_SRC-1:0]              fiq_pend;
    logic [DATA_W-1:0]               live_vec;
    logic [DATA_W-1:0]               vec_out;
    logic                            vec_busy;
    reg_e                            kind;

    assign kind = reg_decode(addr_i);

    vic_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_SLOT(NUM_SLOT),
        .DATA_W  (DATA_W),
        .CH_W    (CH_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .class_o   (class_q),
        .enable_o  (en_q),
        .dflt_o    (dflt_q),
        .slot_en_o (slot_en),
        .slot_ch_o (slot_ch),
        .slot_adr_o(slot_adr)
    );

    assign irq_pend = req_i & en_q & ~class_q;
    assign fiq_pend = req_i & en_q & class_q;
    assign irq_o    = |irq_pend;
    assign fiq_o    = |fiq_pend;

    vic_slot_arb #(
        .NUM_SRC (NUM_SRC),
        .NUM_SLOT(NUM_SLOT),
        .DATA_W  (DATA_W),
        .CH_W    (CH_W)
    ) u_arb (
        .pend_i    (irq_pend),
        .slot_en_i (slot_en),
        .slot_ch_i (slot_ch),
        .slot_adr_i(slot_adr),
        .dflt_i    (dflt_q),
        .vec_o     (live_vec)
    );

    vic_vector #(
        .DATA_W(DATA_W)
    ) u_vec (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fetch_i(rd_en_i && (kind == REG_VECTOR)),
        .done_i (wr_en_i && (kind == REG_VECTOR)),
        .live_i (live_vec),
        .vec_o  (vec_out),
        .busy_o (vec_busy)
    );

    always_comb begin
        rdata_o = '0;
        case (kind)
            REG_CLASS:  rdata_o[NUM_SRC-1:0] = class_q;
            REG_ENSET:  rdata_o[NUM_SRC-1:0] = en_q;
            REG_VECTOR: rdata_o = vec_out;
            REG_DFLT:   rdata_o = dflt_q;
            REG_SCTL: begin
                for (int n = 0; n < NUM_SLOT; n++) begin
                    if (32'(addr_i[5:2]) == n) begin
                        rdata_o[CH_W:0] = {slot_en[n], slot_ch[n]};
                    end
                end
            end
            REG_SADR: begin
                for (int n = 0; n < NUM_SLOT; n++) begin
                    if (32'(addr_i[5:2]) == n) begin
                        rdata_o = slot_adr[n];
                    end
                end
            end
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] req_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic [DATA_W-1:0]  vec_out,
    input logic               vec_busy
);

    logic wr_set, wr_clr, wr_vec, rd_vec;
    assign wr_set = wr_en_i && (addr_i == ADR_ENSET);
    assign wr_clr = wr_en_i && (addr_i == ADR_ENCLR);
    assign wr_vec = wr_en_i && (addr_i == ADR_VECTOR);
    assign rd_vec = rd_en_i && (addr_i == ADR_VECTOR);

    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) (req_i == '0) |-> (!irq_o && !fiq_o)); // R1
    AST_ENSET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_set |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R2
    AST_ENSET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_set |=> ((en_q & $past(en_q)) == $past(en_q))); // R2
    AST_ENCLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_clr |=> ((en_q & $past(wdata_i[NUM_SRC-1:0])) == '0)); // R3
    AST_EN_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni) (!wr_set && !wr_clr) |=> $stable(en_q)); // R3
    AST_VEC_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_vec && !wr_vec) |=> vec_busy); // R8
    AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (vec_busy && !wr_vec) |=> (vec_busy && $stable(vec_out))); // R8
    AST_VEC_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_vec |=> !vec_busy); // R8

endmodule

bind vic_top vic_checker #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o),
    .en_q    (en_q),
    .vec_out (vec_out),
    .vec_busy(vec_busy)
);

// File: tb/vic_top_test.sv
module vic_top_test;

    localparam logic [31:0] DFLT = 32'hDEAD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    logic [31:0] en_m = '0;
    logic [31:0] cls_m = '0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    vic_top uut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .req_i  (req),
        .wr_en_i(wr_en),
        .rd_en_i(rd_en),
        .addr_i (addr),
        .wdata_i(wdata),
        .rdata_o(rdata),
        .irq_o  (irq),
        .fiq_o  (fiq)
    );

    function automatic int ch_of(input int n);
        return (n == 12) ? 7 : (n * 5 + 2) % 32;
    endfunction
    function automatic bit slot_on(input int n);
        return !(n == 3 || n == 9);
    endfunction
    function automatic logic [31:0] adr_of(input int n);
        return 32'h1000_0000 + 32'(n) * 32'h100;
    endfunction
    function automatic logic [31:0] exp_vec(input logic [31:0] r);
        logic [31:0] p;
        p = r & en_m & ~cls_m;
        for (int n = 0; n < 16; n++) begin
            if (slot_on(n) && p[ch_of(n)]) return adr_of(n);
        end
        return DFLT;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_req(input logic [31:0] r);
        @(negedge clk);
        req = r;
        #2;
    endtask

    task automatic out_check(input string tag);
        logic [31:0] p;
        p = req & en_m;
        chk({tag, " irq_o"}, {31'b0, irq}, {31'b0, |(p & ~cls_m)});
        chk({tag, " fiq_o"}, {31'b0, fiq}, {31'b0, |(p & cls_m)});
    endtask

    task automatic vec_case(input logic [31:0] r, input string tag);
        set_req(r);
        out_check({"R1 ", tag});
        do_rd(8'h10, rv);
        chk({"R6/R7 ", tag}, rv, exp_vec(r));
        do_wr(8'h10, 32'h0);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        set_req(32'hFFFF_FFFF);
        chk("R1 reset irq_o", {31'b0, irq}, 32'h0);
        chk("R1 reset fiq_o", {31'b0, fiq}, 32'h0);
        do_rd(8'h00, rv); chk("R4 reset class", rv, 32'h0);
        do_rd(8'h04, rv); chk("R2 reset enable", rv, 32'h0);
        do_rd(8'h10, rv); chk("R7 reset vector", rv, 32'h0);
        do_wr(8'h10, 32'h0);
        set_req(32'h0);

        // enable set / clear
        do_wr(8'h04, 32'hFFFF_FFFF); en_m = 32'hFFFF_FFFF;
        do_rd(8'h04, rv); chk("R2 set all", rv, en_m);
        do_wr(8'h08, 32'h0000_00F0); en_m &= ~32'h0000_00F0;
        do_rd(8'h04, rv); chk("R3 clear nibble", rv, en_m);
        do_wr(8'h08, 32'h0); 
        do_rd(8'h04, rv); chk("R3 clear zeros no effect", rv, en_m);
        do_wr(8'h04, 32'h0000_0030); en_m |= 32'h0000_0030;
        do_rd(8'h04, rv); chk("R2 partial set", rv, en_m);
        do_wr(8'h04, 32'h0); 
        do_rd(8'h04, rv); chk("R2 set zeros no effect", rv, en_m);
        do_wr(8'h04, 32'hFFFF_FFFF); en_m = 32'hFFFF_FFFF;

        // class register
        do_wr(8'h00, 32'hA5A5_0F0F);
        do_rd(8'h00, rv); chk("R4 class readback", rv, 32'hA5A5_0F0F);
        do_wr(8'h00, 32'h0);

        // slot programming
        do_wr(8'h14, DFLT);
        do_rd(8'h14, rv); chk("R7 default readback", rv, DFLT);
        for (int n = 0; n < 16; n++) begin
            do_wr(8'h40 + 8'(4 * n), {26'b0, slot_on(n), 5'(ch_of(n))});
            do_wr(8'h80 + 8'(4 * n), adr_of(n));
        end
        for (int n = 0; n < 16; n++) begin
            do_rd(8'h40 + 8'(4 * n), rv);
            chk("R5 slot control", rv, {26'b0, slot_on(n), 5'(ch_of(n))});
            do_rd(8'h80 + 8'(4 * n), rv);
            chk("R5 slot address", rv, adr_of(n));
        end

        // single-source sweep
        vec_case(32'h0, "no request");
        for (int s = 0; s < 32; s++) vec_case(32'h1 << s, "single");
        // pair sweep, priority between slots
        for (int a = 0; a < 32; a++) vec_case((32'h1 << a) | (32'h1 << ((a * 13 + 5) % 32)), "pair");
        vec_case(32'h0000_0004 | 32'h0800_0000, "R6 slot0 over slot5");

        // fast class
        do_wr(8'h00, 32'h0000_00FF); cls_m = 32'h0000_00FF;
        for (int s = 0; s < 8; s++) vec_case(32'h1 << s, "R9 fast only");
        vec_case(32'h0000_00FF | 32'h0040_0000, "R9 fast plus normal");
        do_wr(8'h00, 32'h0); cls_m = '0;

        // disabled source
        do_wr(8'h08, 32'h0000_0004); en_m &= ~32'h0000_0004;
        vec_case(32'h0000_0004, "R3 disabled alone");
        vec_case(32'h0000_0084, "R3 disabled skips slot0");
        do_wr(8'h04, 32'h0000_0004); en_m |= 32'h0000_0004;

        // freeze and release
        set_req(32'h0800_0000);
        do_rd(8'h10, held); chk("R8 first fetch", held, adr_of(5));
        set_req(32'h0000_0004);
        do_rd(8'h10, rv); chk("R8 frozen while serviced", rv, adr_of(5));
        do_wr(8'h10, 32'h1234_5678);
        do_rd(8'h10, rv); chk("R8 re-arbitrated after end", rv, adr_of(0));
        do_wr(8'h10, 32'h0);
        set_req(32'h0);
        do_rd(8'h10, rv); chk("R7 idle default", rv, DFLT);
        do_wr(8'h10, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule